// File: doc/BRIEF.md
# User-Zone Access Permission Unit

This unit decides, byte by byte, whether a host may read or write a location in one protected user zone of a serial secure memory. It also decides what value actually lands in the array. At the start of each command it takes a snapshot of the zone policy. The snapshot covers the zone's active-low access register, the currently verified password (its kind and its set), the authentication flag and the write-lock byte of the addressed page. Each read or write request in that command is then judged against the snapshot.

A granted read returns the stored byte, and a refused read returns zero. For a write, the unit produces the byte to store. That byte can be the new data, the new data ANDed with the old data when bits may only be cleared, or the untouched old data when the write is refused. When the page uses per-byte write locking, the unit accepts only the first write request of the command. On that request it raises a one-cycle strobe that tells the array controller to start its write cycle.

Top module: `zone_access_checker`

## Requirements
- R1: With access bit 6 at 0, a read is granted only while a verified password (read or write kind) belongs to the zone's set. A refused read returns 8'h00 on `rdData` with `rdPermit` low. A granted read returns `oldByte`.
- R2: With access bit 7 at 0, a write needs a verified write-kind password (`pwIsWrite`=1) of the zone's set. With bit 7 at 1, no password is needed to write.
- R3: The zone's set is the value of access bit 3 (0 selects set 0, 1 selects set 1). A verified password whose `pwSet` differs grants neither read nor write rights in the zone.
- R4: With access bit 5 at 0, both reads and writes also need `authDone`=1.
- R5: With access bit 5 at 1 and access bit 4 at 0, writes need `authDone`=1 and reads do not.
- R6: With access bit 1 at 0, every write is refused.
- R7: With access bit 0 at 0, a granted write stores `oldByte & newByte`. Otherwise a granted write stores `newByte` (subject to R8).
- R8: With access bit 2 at 0 (lock mode), a write to page byte k (`byteOffset`=k) is refused when bit k of the lock byte is 0. A granted write to byte 0 stores `oldByte & newByte`.
- R9: In lock mode, only the first write request of a command can be granted. That request (granted or not) pulses `lockCommit` for one cycle, and later writes in the same command are refused.
- R10: A refused write presents `oldByte` on `wrData`, so the location keeps its value.
- R11: Policy inputs are sampled on the cycle with `cmdStart`=1. Changes to them later in the command have no effect on any decision.
- R12: Results appear on the outputs one clock after the request. After reset, and for requests outside a command (after `cmdEnd`), all outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdStart | input | 1 | Opens a command and samples the policy inputs |
| cmdEnd | input | 1 | Closes the command |
| accessReg | input | 8 | Zone access register, active-low bits |
| pwValid | input | 1 | A password is currently verified |
| pwIsWrite | input | 1 | Verified password is the write kind |
| pwSet | input | 1 | Set index of the verified password |
| authDone | input | 1 | Authentication completed |
| lockByte | input | 8 | Byte 0 of the addressed page (per-byte write locks) |
| byteOffset | input | 3 | Byte position within the 8-byte page |
| rdReq | input | 1 | Read request for the current byte |
| wrReq | input | 1 | Write request for the current byte |
| oldByte | input | 8 | Byte currently stored |
| newByte | input | 8 | Byte sent by the host |
| rdPermit | output | 1 | Read granted |
| rdData | output | 8 | Byte returned to the host |
| wrPermit | output | 1 | Write granted |
| wrData | output | 8 | Byte to store |
| lockCommit | output | 1 | Lock-mode write accepted, start the write cycle |

## Verification
The hardest case to reach from the ports is a decision that depends on the sampled policy rather than on the live inputs. To exercise it, the stimulus inverts every policy input on the cycle after `cmdStart` and holds the inversion for the rest of the command. Any leak of live values into a decision then flips the expected result. The second write of each command checks the lock-mode single-byte rule: it targets another byte of the same page, and in lock mode it must be refused even when its lock bit would allow it. The sweep runs every access-register value against every password kind and set and both authentication states, so each stacked policy meets every other.

// File: rtl/zac_pkg.sv
package zac_pkg;
  localparam int DATA_W     = 8;
  localparam int PAGE_BYTES = 8;
  localparam int ACC_W      = 8;

  // active-low access register bit positions
  localparam int ACC_WPW  = 7;
  localparam int ACC_RPW  = 6;
  localparam int ACC_AUTH = 5;
  localparam int ACC_AWO  = 4;
  localparam int ACC_SET  = 3;
  localparam int ACC_LOCK = 2;
  localparam int ACC_NOWR = 1;
  localparam int ACC_PROG = 0;

  typedef struct packed {
    logic [ACC_W-1:0]      acc;
    logic                  pwValid;
    logic                  pwIsWrite;
    logic                  pwSet;
    logic                  authDone;
    logic [PAGE_BYTES-1:0] lock;
  } policy_t;

  typedef struct packed {
    logic capture;
    logic rdGo;
    logic wrGo;
    logic lockSpent;
  } strobe_t;
endpackage

// File: rtl/zac_ctrl.sv
module zac_ctrl
  import zac_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdStart,
  input  logic    cmdEnd,
  input  logic    rdReq,
  input  logic    wrReq,
  output strobe_t strb
);
  logic activeQ;
  logic spentQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      spentQ  <= 1'b0;
    end else if (cmdStart) begin
      activeQ <= 1'b1;
      spentQ  <= 1'b0;
    end else begin
      if (cmdEnd) activeQ <= 1'b0;
      if (wrReq && activeQ) spentQ <= 1'b1;
    end
  end

  always_comb begin
    strb.capture   = cmdStart;
    strb.rdGo      = rdReq && activeQ && !cmdStart;
    strb.wrGo      = wrReq && activeQ && !cmdStart;
    strb.lockSpent = spentQ;
  end

  // R9: a new command always starts with its first write still available
  p_spent_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> !strb.lockSpent);

  // R12: no request is forwarded once the command has closed
  p_closed_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    (cmdEnd && !cmdStart) |=> !strb.rdGo && !strb.wrGo);
endmodule

// File: rtl/zac_datapath.sv
module zac_datapath
  import zac_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int PB = PAGE_BYTES,
  localparam int OW = $clog2(PB)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  policy_t       polIn,
  input  logic [OW-1:0] byteOffset,
  input  logic [DW-1:0] oldByte,
  input  logic [DW-1:0] newByte,
  output logic          rdPermit,
  output logic [DW-1:0] rdData,
  output logic          wrPermit,
  output logic [DW-1:0] wrData,
  output logic          lockCommit
);
  policy_t polQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             polQ <= '0;
    else if (strb.capture) polQ <= polIn;
  end

  logic setMatch, rdPwOk, wrPwOk, rdAuthOk, wrAuthOk;
  logic lockMode, lockBitOk, progOnly, rdOk, wrOk;
  logic [DW-1:0] mergedByte;

  always_comb begin
    setMatch  = polQ.pwValid && (polQ.pwSet == polQ.acc[ACC_SET]);
    rdPwOk    = polQ.acc[ACC_RPW] || setMatch;
    wrPwOk    = polQ.acc[ACC_WPW] || (setMatch && polQ.pwIsWrite);
    rdAuthOk  = polQ.acc[ACC_AUTH] || polQ.authDone;
    wrAuthOk  = (polQ.acc[ACC_AUTH] && polQ.acc[ACC_AWO]) || polQ.authDone;
    lockMode  = !polQ.acc[ACC_LOCK];
    lockBitOk = !lockMode || polQ.lock[byteOffset];
    progOnly  = !polQ.acc[ACC_PROG] || (lockMode && byteOffset == '0);
    rdOk      = rdPwOk && rdAuthOk;
    wrOk      = wrPwOk && wrAuthOk && polQ.acc[ACC_NOWR] && lockBitOk
                && !(lockMode && strb.lockSpent);
  end

  for (genvar i = 0; i < DW; i++) begin : g_merge
    assign mergedByte[i] = progOnly ? (oldByte[i] & newByte[i]) : newByte[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPermit   <= 1'b0;
      rdData     <= '0;
      wrPermit   <= 1'b0;
      wrData     <= '0;
      lockCommit <= 1'b0;
    end else begin
      rdPermit   <= strb.rdGo && rdOk;
      rdData     <= (strb.rdGo && rdOk) ? oldByte : '0;
      wrPermit   <= strb.wrGo && wrOk;
      wrData     <= !strb.wrGo ? '0 : (wrOk ? mergedByte : oldByte);
      lockCommit <= strb.wrGo && lockMode && !strb.lockSpent;
    end
  end

  // R1: a read without a matching password in a protected zone yields zero
  p_rd_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdGo |=> (rdPermit || rdData == '0));

  // R6: modify-forbidden zones never grant a write
  p_no_modify_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrGo && !polQ.acc[ACC_NOWR]) |=> !wrPermit);

  // R7: program-only writes never set a bit
  p_prog_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrGo && !polQ.acc[ACC_PROG]) |=> ((wrData & ~$past(oldByte)) == '0));

  // R8: a cleared lock bit refuses its byte
  p_lock_bit_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrGo && !polQ.acc[ACC_LOCK] && !polQ.lock[byteOffset]) |=> !wrPermit);

  // R9: only the first write of a lock-mode command can pass
  p_lock_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrGo && !polQ.acc[ACC_LOCK] && strb.lockSpent) |=> !wrPermit && !lockCommit);

  // R10: a refused write hands back the stored byte
  p_keep_old_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrGo |=> (wrPermit || wrData == $past(oldByte)));
endmodule

// File: rtl/zone_access_checker.sv
module zone_access_checker
  import zac_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic       cmdEnd,
  input  logic [7:0] accessReg,
  input  logic       pwValid,
  input  logic       pwIsWrite,
  input  logic       pwSet,
  input  logic       authDone,
  input  logic [7:0] lockByte,
  input  logic [2:0] byteOffset,
  input  logic       rdReq,
  input  logic       wrReq,
  input  logic [7:0] oldByte,
  input  logic [7:0] newByte,
  output logic       rdPermit,
  output logic [7:0] rdData,
  output logic       wrPermit,
  output logic [7:0] wrData,
  output logic       lockCommit
);
  strobe_t strb;
  policy_t polIn;

  always_comb begin
    polIn.acc       = accessReg;
    polIn.pwValid   = pwValid;
    polIn.pwIsWrite = pwIsWrite;
    polIn.pwSet     = pwSet;
    polIn.authDone  = authDone;
    polIn.lock      = lockByte;
  end

  zac_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdStart (cmdStart),
    .cmdEnd   (cmdEnd),
    .rdReq    (rdReq),
    .wrReq    (wrReq),
    .strb     (strb)
  );

  zac_datapath #(.DW(DATA_W), .PB(PAGE_BYTES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .polIn      (polIn),
    .byteOffset (byteOffset),
    .oldByte    (oldByte),
    .newByte    (newByte),
    .rdPermit   (rdPermit),
    .rdData     (rdData),
    .wrPermit   (wrPermit),
    .wrData     (wrData),
    .lockCommit (lockCommit)
  );

  // R12: permits only ever follow a request
  p_permit_needs_req_r12: assert property (@(posedge clk) disable iff (!rstN)
    (rdPermit || wrPermit) |-> $past(rdReq || wrReq));
endmodule

// File: tb/zone_access_checker_test.sv
`timescale 1ns/1ps
module zone_access_checker_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdStart = 0, cmdEnd = 0, pwValid = 0, pwIsWrite = 0, pwSet = 0, authDone = 0;
  logic [7:0] accessReg = 8'hFF, lockByte = 8'hFF, oldByte = 0, newByte = 0;
  logic [2:0] byteOffset = 0;
  logic rdReq = 0, wrReq = 0;
  logic rdPermit, wrPermit, lockCommit;
  logic [7:0] rdData, wrData;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  zone_access_checker uut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdEnd(cmdEnd),
    .accessReg(accessReg), .pwValid(pwValid), .pwIsWrite(pwIsWrite), .pwSet(pwSet),
    .authDone(authDone), .lockByte(lockByte), .byteOffset(byteOffset),
    .rdReq(rdReq), .wrReq(wrReq), .oldByte(oldByte), .newByte(newByte),
    .rdPermit(rdPermit), .rdData(rdData), .wrPermit(wrPermit), .wrData(wrData),
    .lockCommit(lockCommit)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic setOk(input logic [7:0] a, input logic pv, input logic ps);
    return pv && (ps == a[3]);                            // R3
  endfunction

  function automatic logic expRd(input logic [7:0] a, input logic pv, input logic ps,
                                 input logic au);
    return (a[6] || setOk(a, pv, ps))                     // R1
           && (a[5] || au);                               // R4, R5: reads skip bit 4
  endfunction

  function automatic logic expWr(input logic [7:0] a, input logic pv, input logic pw,
                                 input logic ps, input logic au, input logic [7:0] lk,
                                 input int off, input logic spent);
    return (a[7] || (setOk(a, pv, ps) && pw))             // R2
           && ((a[5] && a[4]) || au)                      // R4, R5
           && a[1]                                        // R6
           && (a[2] || lk[off])                           // R8
           && !(!a[2] && spent);                          // R9
  endfunction

  function automatic logic [7:0] expWd(input logic ok, input logic [7:0] a, input int off,
                                       input logic [7:0] o, input logic [7:0] n);
    if (!ok) return o;                                    // R10
    if (!a[0] || (!a[2] && off == 0)) return o & n;       // R7, R8
    return n;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R12: reset state
    chk("R12 reset rdPermit", {7'd0, rdPermit}, 8'h00);
    chk("R12 reset wrPermit", {7'd0, wrPermit}, 8'h00);
    chk("R12 reset data", rdData | wrData, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    for (int a = 0; a < 256; a++) begin
      for (int c = 0; c < 8; c++) begin
        for (int au = 0; au < 2; au++) begin
          logic [7:0] acc, lk, o1, n1, o2, n2;
          logic pv, pw, ps, ok;
          int offA, offB;
          acc = a[7:0];
          pv = c[0]; pw = c[1]; ps = c[2];
          lk = 8'(a * 37 + c * 11 + au * 90);
          offA = (a + c + au) % 8;
          offB = (offA + 3) % 8;
          o1 = 8'(a ^ 8'h5A) + 8'(c);
          n1 = ~o1 ^ 8'(c * 29 + au);
          o2 = 8'(a * 3 + 7);
          n2 = 8'(c * 53) ^ 8'hC3;

          // open command with the real policy
          accessReg = acc; pwValid = pv; pwIsWrite = pw; pwSet = ps;
          authDone = au[0]; lockByte = lk; cmdStart = 1'b1;
          @(negedge clk);
          // R11: scramble live policy for the rest of the command
          cmdStart = 1'b0;
          accessReg = ~acc; pwValid = ~pv; pwIsWrite = ~pw; pwSet = ~ps;
          authDone = ~au[0]; lockByte = ~lk;
          rdReq = 1'b1; byteOffset = 3'(offA); oldByte = o1; newByte = n1;
          @(negedge clk);
          ok = expRd(acc, pv, ps, au[0]);
          chk("R1 R11 rdPermit", {7'd0, rdPermit}, {7'd0, ok});
          chk("R1 rdData", rdData, ok ? o1 : 8'h00);
          rdReq = 1'b0; wrReq = 1'b1;
          @(negedge clk);
          ok = expWr(acc, pv, pw, ps, au[0], lk, offA, 1'b0);
          chk("R2 R11 wrPermit", {7'd0, wrPermit}, {7'd0, ok});
          chk("R7 R10 wrData", wrData, expWd(ok, acc, offA, o1, n1));
          chk("R9 lockCommit first", {7'd0, lockCommit}, {7'd0, ~acc[2]});
          byteOffset = 3'(offB); oldByte = o2; newByte = n2;
          @(negedge clk);
          ok = expWr(acc, pv, pw, ps, au[0], lk, offB, 1'b1);
          chk("R9 second wrPermit", {7'd0, wrPermit}, {7'd0, ok});
          chk("R8 second wrData", wrData, expWd(ok, acc, offB, o2, n2));
          chk("R9 lockCommit second", {7'd0, lockCommit}, 8'h00);
          wrReq = 1'b0; cmdEnd = 1'b1;
          @(negedge clk);
          cmdEnd = 1'b0;
        end
      end
    end

    // R12: requests outside a command give nothing
    accessReg = 8'hFF; rdReq = 1'b1; wrReq = 1'b1; oldByte = 8'hA5; newByte = 8'h3C;
    @(negedge clk);
    chk("R12 idle rdPermit", {7'd0, rdPermit}, 8'h00);
    chk("R12 idle wrPermit", {7'd0, wrPermit}, 8'h00);
    chk("R12 idle data", rdData | wrData, 8'h00);
    rdReq = 1'b0; wrReq = 1'b0;
    @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule